// File: doc/BRIEF.md
# Break-Aware Asynchronous Serial Receiver with Tagged Receive FIFO

This block receives 8-bit asynchronous serial frames: one start bit, eight data bits sent least significant bit first, and one stop bit. The RX line is sampled with a 16x oversampling tick that comes from outside the block. Each received byte goes into a receive FIFO together with a one-bit framing-error tag. A status word always reports the tag of the entry at the FIFO head, so software learns whether the byte it is about to read was damaged before it pops that byte.

The block recognises a line break. A break is a frame with a framing error followed by a further frame that completes while the line has stayed at space. When a break is recognised, the block raises a sticky break flag. It then keeps the all-zero bytes produced by the held-low line out of the FIFO until the line returns to mark. The break flag clears only through a read-then-clear handshake. A separate sticky overrun flag records bytes lost because the FIFO was full.

The frame assembler runs through states `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`:
- `RX_IDLE` → `RX_START` on the first tick that sees the line low.
- `RX_START` → `RX_IDLE` if the 8th sample is high (false start).
- `RX_START` → `RX_DATA` if the 8th sample is low.
- `RX_DATA` → `RX_STOP` after the eighth bit.
- `RX_STOP` → `RX_IDLE` on the stop-bit centre sample, which completes the frame.

The break tracker runs through states `BK_MARK`, `BK_SUSPECT` and `BK_SPACE`:
- `BK_MARK` → `BK_SUSPECT` when a frame has a framing error.
- `BK_SUSPECT` → `BK_MARK` when the line is seen high.
- `BK_SUSPECT` → `BK_SPACE` when another zero frame with a framing error completes. This transition raises the break flag.
- `BK_SUSPECT` → `BK_SUSPECT` when a nonzero frame with a framing error completes.
- `BK_SUSPECT` → `BK_MARK` when a clean frame completes.
- `BK_SPACE` → `BK_MARK` when the line returns high.

Top module: `uart_brk_rx`

## Requirements
- R1: A frame is 1 start bit (0), 8 data bits sent LSB first, and 1 stop bit. Each data bit is sampled on its 8th of 16 ticks. Each completed frame is written to the FIFO with its byte on `rdata_o` when it reaches the head.
- R2: If the stop-bit sample is 0, the frame's tag is set to 1 and the byte is still stored. If the stop-bit sample is 1, the tag is 0.
- R3: `stat_o[2]` equals the tag of the FIFO head entry and reads 0 when the FIFO is empty. `stat_o[3]` is 1 exactly when the FIFO holds data.
- R4: The FIFO returns bytes in arrival order and holds DEPTH (16) entries. A pulse on `data_rd_i` removes the head entry. A pulse on an empty FIFO changes nothing.
- R5: A frame that completes while the FIFO is full is discarded, and the overrun flag `stat_o[1]` is set. A status write with `stat_wdata_i[1]` = 0 clears the flag. A write with that bit = 1 leaves the flag unchanged.
- R6: The break flag `stat_o[0]` is set when a frame with a tag of 1 is followed by another zero-data frame with a tag of 1, with no high line sample in between. A single bad-stop frame followed by mark does not set it.
- R7: Once a break is recognised, zero-data frames are not stored. The first damaged frame (0x00, tag 1) stays in the FIFO. After the line returns to 1, frames are stored normally again.
- R8: A status write with `stat_wdata_i[0]` = 0 clears the break flag only if the last `stat_rd_i` read returned the flag as 1. A read that returned 0, or no read at all, leaves the flag set. A write with that bit = 1 never clears it.
- R9: After reset, `stat_o` is all zero.
- R10: A low pulse shorter than 8 ticks is rejected at the start-bit centre check and produces no FIFO entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | 16x oversampling enable |
| rx_i | input | 1 | Serial receive line, idle high |
| data_rd_i | input | 1 | Pop the FIFO head entry |
| rdata_o | output | 8 | Byte at the FIFO head |
| stat_rd_i | input | 1 | Status read strobe; records the break flag value seen |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 2 | Write data: bit0 keeps break flag, bit1 keeps overrun flag |
| stat_o | output | 4 | {FIFO holds data, head tag, overrun, break} |

## Verification
The bench builds the block with DEPTH = 16 and OVS = 16, and holds `tick16_i` high on every clock. Each bit time is therefore exactly 16 cycles. This makes exact frame timing possible: the break stimulus can hold the line low for exactly five receive frames, then release it before the sixth start-bit check, so the expected FIFO contents after a break are fully determined. With a depth of 16, overrun is reached after seventeen frames, and the full-FIFO drop and the clear of the overrun flag are both checked within the cycle limit.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        BK_MARK,
        BK_SUSPECT,
        BK_SPACE
    } brk_state_e;

    localparam int STAT_W      = 4;
    localparam int ST_BRK      = 0;
    localparam int ST_OVR      = 1;
    localparam int ST_FER      = 2;
    localparam int ST_NONEMPTY = 3;

endpackage

// File: rtl/uart_brk_frame.sv
module uart_brk_frame
    import uart_brk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              line_o,
    output logic              done_o,
    output logic              fer_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DATA_W);
    localparam int HALF = OVS / 2;

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [BW-1:0]     bit_q, bit_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              done_d, fer_d, fer_q, done_q;
    logic [1:0]        sync_q;
    logic              line;

    // two-stage synchroniser, idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end
    assign line   = sync_q[1];
    assign line_o = line;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            done_q  <= 1'b0;
            fer_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            done_q  <= done_d;
            fer_q   <= fer_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        done_d  = 1'b0;
        fer_d   = fer_q;
        unique case (state_q)
            RX_IDLE: begin
                if (tick_i && !line) begin
                    state_d = RX_START;
                    cnt_d   = '0;
                end
            end
            RX_START: begin
                if (tick_i) begin
                    if (cnt_q == CW'(HALF - 1)) begin
                        cnt_d = '0;
                        bit_d = '0;
                        state_d = line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick_i) begin
                    if (cnt_q == CW'(OVS - 1)) begin
                        cnt_d = '0;
                        sh_d  = {line, sh_q[DATA_W-1:1]};
                        if (bit_q == BW'(DATA_W - 1)) state_d = RX_STOP;
                        else                          bit_d   = bit_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick_i) begin
                    if (cnt_q == CW'(OVS - 1)) begin
                        cnt_d   = '0;
                        state_d = RX_IDLE;
                        done_d  = 1'b1;
                        fer_d   = !line;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    assign done_o = done_q;
    assign fer_o  = fer_q;
    assign data_o = sh_q;

    // R1: a completed frame always comes out of the stop state
    p_done_from_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(state_q) == RX_STOP);

endmodule

// File: rtl/uart_brk_fifo.sv
module uart_brk_fifo #(
    parameter int EW    = 9,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [EW-1:0] din_i,
    input  logic          pop_i,
    output logic [EW-1:0] dout_o,
    output logic          empty_o,
    output logic          drop_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full || do_pop);
    assign drop_o  = push_i && !do_push;
    assign dout_o  = mem[rd_q];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4: occupancy never exceeds the depth
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R5: a dropped write leaves the occupancy untouched
    p_drop_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_o && !pop_i) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_brk_flags.sv
module uart_brk_flags
    import uart_brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic fer_i,
    input  logic zero_i,
    input  logic line_i,
    input  logic drop_i,
    input  logic stat_rd_i,
    input  logic stat_wr_i,
    input  logic keep_brk_i,
    input  logic keep_ovr_i,
    output logic push_o,
    output logic brk_o,
    output logic ovr_o
);
    brk_state_e bk_q, bk_d;
    logic       brk_q, armed_q, ovr_q;
    logic       brk_set, brk_clr, ovr_clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= BK_MARK;
        else        bk_q <= bk_d;
    end

    always_comb begin
        bk_d = bk_q;
        unique case (bk_q)
            BK_MARK: begin
                if (done_i && fer_i) bk_d = BK_SUSPECT;
            end
            BK_SUSPECT: begin
                if (done_i) begin
                    if (fer_i && zero_i) bk_d = BK_SPACE;
                    else if (fer_i)      bk_d = BK_SUSPECT;
                    else                 bk_d = BK_MARK;
                end else if (line_i) begin
                    bk_d = BK_MARK;
                end
            end
            BK_SPACE: begin
                if (line_i) bk_d = BK_MARK;
            end
            default: bk_d = BK_MARK;
        endcase
    end

    // outputs
    always_comb begin
        brk_set = (bk_q == BK_SUSPECT) && done_i && fer_i && zero_i;
        push_o  = done_i && !(zero_i && ((bk_q == BK_SPACE) || brk_set));
        brk_clr = stat_wr_i && !keep_brk_i && armed_q && brk_q;
        ovr_clr = stat_wr_i && !keep_ovr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q   <= 1'b0;
            armed_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (brk_set)      brk_q <= 1'b1;
            else if (brk_clr) brk_q <= 1'b0;
            if (brk_clr)        armed_q <= 1'b0;
            else if (stat_rd_i) armed_q <= brk_q;
            if (drop_i)       ovr_q <= 1'b1;
            else if (ovr_clr) ovr_q <= 1'b0;
        end
    end

    assign brk_o = brk_q;
    assign ovr_o = ovr_q;

    // R6: the break flag only rises on a completed damaged frame
    p_brk_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_q) |-> $past(done_i && fer_i));

    // R8: the break flag only falls after an armed clearing write
    p_brk_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_q) |-> $past(stat_wr_i && !keep_brk_i && armed_q));

    // R5: the overrun flag only falls after a clearing write
    p_ovr_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_q) |-> $past(stat_wr_i && !keep_ovr_i));

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_i,
    input  logic              rx_i,
    input  logic              data_rd_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              stat_rd_i,
    input  logic              stat_wr_i,
    input  logic [1:0]        stat_wdata_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam int EW = DATA_W + 1;

    logic              line, done, fer, push, drop, empty, brk, ovr;
    logic [DATA_W-1:0] data;
    logic [EW-1:0]     head;

    uart_brk_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick16_i),
        .rx_i   (rx_i),
        .line_o (line),
        .done_o (done),
        .fer_o  (fer),
        .data_o (data)
    );

    uart_brk_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .fer_i      (fer),
        .zero_i     (data == '0),
        .line_i     (line),
        .drop_i     (drop),
        .stat_rd_i  (stat_rd_i),
        .stat_wr_i  (stat_wr_i),
        .keep_brk_i (stat_wdata_i[ST_BRK]),
        .keep_ovr_i (stat_wdata_i[ST_OVR]),
        .push_o     (push),
        .brk_o      (brk),
        .ovr_o      (ovr)
    );

    uart_brk_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   ({fer, data}),
        .pop_i   (data_rd_i),
        .dout_o  (head),
        .empty_o (empty),
        .drop_o  (drop)
    );

    always_comb begin
        rdata_o                 = head[DATA_W-1:0];
        stat_o                  = '0;
        stat_o[ST_BRK]          = brk;
        stat_o[ST_OVR]          = ovr;
        stat_o[ST_FER]          = !empty && head[DATA_W];
        stat_o[ST_NONEMPTY]     = !empty;
    end

endmodule

// File: tb/sim_uart_brk_rx.sv
module sim_uart_brk_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       data_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic [1:0] wdata = 2'b11;
    logic [7:0] rdata;
    logic [3:0] stat;

    int tests = 0;
    int fails = 0;
    logic [8:0] expq[$];

    always #5 clk = ~clk;

    uart_brk_rx #(.DATA_W(8), .OVS(16), .DEPTH(16)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16_i     (1'b1),
        .rx_i         (rx),
        .data_rd_i    (data_rd),
        .rdata_o      (rdata),
        .stat_rd_i    (stat_rd),
        .stat_wr_i    (stat_wr),
        .stat_wdata_i (wdata),
        .stat_o       (stat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one frame, stop bit value chosen, then one idle bit
    task automatic send(input logic [7:0] d, input bit stop, input bit keep);
        if (keep) expq.push_back({~stop, d});
        repeat (16) @(negedge clk) rx = 1'b0;
        for (int i = 0; i < 8; i++) repeat (16) @(negedge clk) rx = d[i];
        repeat (16) @(negedge clk) rx = stop;
        repeat (16) @(negedge clk) rx = 1'b1;
    endtask

    // monitor: pop and compare against the scoreboard queue
    task automatic drain(input string req);
        logic [8:0] e;
        while (expq.size() > 0) begin
            e = expq.pop_front();
            @(negedge clk);
            chk(stat[3] == 1'b1, req, stat[3], 1);
            chk(stat[2] == e[8], req, stat[2], e[8]);
            chk(rdata == e[7:0], req, rdata, e[7:0]);
            data_rd = 1'b1;
            @(negedge clk) data_rd = 1'b0;
        end
        @(negedge clk);
        chk(stat[3:2] == 2'b00, {req, " empty"}, stat[3:2], 0);
    endtask

    task automatic rd_stat(output logic [3:0] v);
        @(negedge clk) stat_rd = 1'b1;
        v = stat;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic wr_stat(input logic [1:0] v);
        @(negedge clk) begin stat_wr = 1'b1; wdata = v; end
        @(negedge clk) begin stat_wr = 1'b0; wdata = 2'b11; end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat == 4'h0, "R9 reset status", stat, 0);

        // R1 R2 R3: clean and damaged frames, head tag tracking
        send(8'h3C, 1'b1, 1'b1);
        send(8'hC3, 1'b1, 1'b1);
        send(8'hA5, 1'b0, 1'b1);
        send(8'h5A, 1'b1, 1'b1);
        chk(stat[0] == 1'b0, "R6 single bad stop no break", stat[0], 0);
        drain("R1 R2 R3 order and tag");

        // R10: short low glitch
        repeat (5) @(negedge clk) rx = 1'b0;
        repeat (300) @(negedge clk) rx = 1'b1;
        chk(stat == 4'h0, "R10 glitch ignored", stat, 0);

        // R8: read returning 0 so the flag is not armed
        rd_stat(v);
        chk(v[0] == 1'b0, "R8 read before break", v[0], 0);

        // R6 R7: break of five frame times, then mark
        expq.push_back(9'h100);
        repeat (769) @(negedge clk) rx = 1'b0;
        repeat (200) @(negedge clk) rx = 1'b1;
        chk(stat[0] == 1'b1, "R6 break flag set", stat[0], 1);
        wr_stat(2'b00);
        chk(stat[0] == 1'b1, "R8 clear without armed read", stat[0], 1);
        send(8'h81, 1'b1, 1'b1);
        drain("R7 break bytes withheld then resume");
        rd_stat(v);
        chk(v[0] == 1'b1, "R8 read sees break", v[0], 1);
        wr_stat(2'b01);
        chk(stat[0] == 1'b1, "R8 write of 1 keeps break", stat[0], 1);
        wr_stat(2'b00);
        chk(stat[0] == 1'b0, "R8 armed clear", stat[0], 0);

        // R4 R5: overflow by one
        for (int i = 0; i < 17; i++) send(8'h10 + 8'(i), 1'b1, i < 16);
        chk(stat[1] == 1'b1, "R5 overrun set", stat[1], 1);
        wr_stat(2'b10);
        chk(stat[1] == 1'b1, "R5 write of 1 keeps overrun", stat[1], 1);
        drain("R4 R5 full fifo contents");
        wr_stat(2'b00);
        chk(stat[1] == 1'b0, "R5 overrun cleared", stat[1], 0);

        // R4: pop on empty has no effect
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
        chk(stat == 4'h0, "R4 empty pop", stat, 0);
        send(8'hE7, 1'b1, 1'b1);
        drain("R4 after empty pop");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule